// File: doc/BRIEF.md
# Ethernet Controller Register Bank and Interrupt Logic

This block holds the 64 sixteen-bit control and status words of an Ethernet controller and sits between a word-addressed host bus and the controller's engines (transmit, receive, timer, resource fetch, address-table load). A host write to the command word is turned into one-cycle command pulses for those engines. The block also applies the per-register write rules: bit masks, write-one-to-clear status bits, counters that store the inverse of what is written, and configuration words that accept writes only while the device is held in software reset.

Engines report events by pulsing bits of `isr_set`. They report completion of long operations on `engine_done`. A single level interrupt output is high whenever an enabled status bit is pending. Reads are combinational: `host_rdata` follows `host_addr` while `host_rd` is high.

Register index is `host_addr[STRIDE_SHIFT +: 6]`. Indices used below: 0x00 command, 0x01 data configuration, 0x02 receive control, 0x03 transmit control, 0x04 interrupt mask, 0x05 interrupt status, 0x13 end-of-buffer count, 0x15 to 0x18 ring pointers, 0x22 to 0x24 address-table read ports, 0x28 revision, 0x2C to 0x2E tally counters, 0x2F read-only tally, 0x3F second configuration.

Top module: `nicr_regblock`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the interrupt mask (0x04) and the interrupt status (0x05) is nonzero. It follows both registers in the cycle after they change.
- R2: After `rst_n` low, the command word reads 0x0094 (bits 7, 4 and 2 set). Mask and status read 0. Index 0x13 reads 0x02F8, index 0x28 reads REVISION, and every other index reads 0.
- R3: While command bit 7 (software reset) is set, a command write whose data has bit 7 clear only clears bit 7. No pulse is issued and no other bit changes.
- R4: An accepted command write ORs (data & 0x03BF) into the command word. In the cycle after the write, `cmd_pulse[b]` is high for one cycle for each bit b of data & 0x03BF. Bit positions: 0 halt transmit, 1 transmit, 2 receiver disable, 3 receiver enable, 4 timer stop, 5 timer start, 7 software reset, 8 read resource, 9 load address table.
- R5: Within one accepted write, the effects apply in this order: receiver disable clears bit 3, then receiver enable clears bit 2, then timer stop clears bit 5, then timer start clears bit 4.
- R6: An accepted write with bit 7 set then clears bits 9, 8, 1 and 0, and sets bits 7 and 2.
- R7: Command bits 1, 8 and 9 stay set until `engine_done[0]`, `engine_done[1]` or `engine_done[2]` respectively is pulsed. The pulse clears that bit at the next edge.
- R8: A status write clears each bit set in both the data and the current status. A bit pulsed on `isr_set` is set, and a set wins over a clear. Clearing status bit 5 also pulses `cmd_pulse[8]` and sets command bit 8.
- R9: Writes are masked as follows: mask register 0x7FFF, transmit control 0xF000, receive control 0xFFE0, ring pointers 0x15 to 0x18 with 0xFFFE. Other plain registers store all 16 bits.
- R10: Index 0x01 (mask 0xBFFF) and index 0x3F (mask 0xF017) accept writes only while command bit 7 is set. Otherwise the write is dropped.
- R11: Indices 0x2C to 0x2E store the bitwise inverse of the written data. Writes to indices 0x22 to 0x24, 0x28 and 0x2F have no effect; the first three and 0x2F read 0, and 0x28 reads REVISION.
- R12: An access whose `host_addr` bits below STRIDE_SHIFT are not all zero is ignored: a write changes nothing and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | STRIDE_SHIFT+6 | Host byte address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, combinational |
| isr_set | input | 16 | Status bits to set, one-cycle pulses from engines |
| engine_done | input | 3 | Completion strobes: transmit, read resource, address-table load |
| cmd_pulse | output | 10 | One-cycle command pulses, bit positions as in the command word |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with STRIDE_SHIFT = 2 and REVISION = 0x0004. With a two-bit alignment field, both low-bit offsets 1 and 2 can be driven, which exercises the misaligned-access rule. A fixed revision lets the read-only word be checked against a known constant. Random writes across every plain, masked, gated, inverted and read-only index are checked once while the device is held in reset and again after it leaves reset, so the gated words are seen both accepting and dropping data. Directed sequences cover the reset-exit rule, mutually cancelling commands in one write, busy bits held until their done strobe, and the status-clear that starts a resource read.

// File: rtl/nicr_pkg.sv
package nicr_pkg;

  localparam int IDX_W = 6;
  localparam int NREGS = 1 << IDX_W;
  localparam int CMD_W = 10;

  typedef logic [CMD_W-1:0] cmd_vec_t;

  // register indices whose behaviour depends on position
  localparam logic [IDX_W-1:0] IX_CR      = 6'h00;
  localparam logic [IDX_W-1:0] IX_DCR     = 6'h01;
  localparam logic [IDX_W-1:0] IX_RCR     = 6'h02;
  localparam logic [IDX_W-1:0] IX_TCR     = 6'h03;
  localparam logic [IDX_W-1:0] IX_IMR     = 6'h04;
  localparam logic [IDX_W-1:0] IX_ISR     = 6'h05;
  localparam logic [IDX_W-1:0] IX_EOBC    = 6'h13;
  localparam logic [IDX_W-1:0] IX_RING_LO = 6'h15;
  localparam logic [IDX_W-1:0] IX_RING_HI = 6'h18;
  localparam logic [IDX_W-1:0] IX_CAP_LO  = 6'h22;
  localparam logic [IDX_W-1:0] IX_CAP_HI  = 6'h24;
  localparam logic [IDX_W-1:0] IX_REV     = 6'h28;
  localparam logic [IDX_W-1:0] IX_TAL_LO  = 6'h2C;
  localparam logic [IDX_W-1:0] IX_TAL_HI  = 6'h2E;
  localparam logic [IDX_W-1:0] IX_TAL_RO  = 6'h2F;
  localparam logic [IDX_W-1:0] IX_DCR2    = 6'h3F;

  // command word bit positions
  localparam int CB_HALT   = 0;
  localparam int CB_TX     = 1;
  localparam int CB_RXDIS  = 2;
  localparam int CB_RXEN   = 3;
  localparam int CB_TSTOP  = 4;
  localparam int CB_TSTART = 5;
  localparam int CB_SWRST  = 7;
  localparam int CB_RSRC   = 8;
  localparam int CB_CAM    = 9;

  localparam logic [15:0] CMD_MASK  = 16'h03BF;
  localparam logic [15:0] CR_RESET  = 16'h0094;
  localparam logic [15:0] EOBC_INIT = 16'h02F8;
  localparam logic [15:0] IMR_MASK  = 16'h7FFF;
  localparam int ISR_RBE = 5;

  localparam int DN_TX   = 0;
  localparam int DN_RSRC = 1;
  localparam int DN_CAM  = 2;

  function automatic logic [15:0] wmask(input logic [IDX_W-1:0] idx);
    logic [15:0] m;
    m = 16'hFFFF;
    if (idx == IX_DCR)  m = 16'hBFFF;
    if (idx == IX_DCR2) m = 16'hF017;
    if (idx == IX_RCR)  m = 16'hFFE0;
    if (idx == IX_TCR)  m = 16'hF000;
    if (idx == IX_IMR)  m = IMR_MASK;
    if (idx >= IX_RING_LO && idx <= IX_RING_HI) m = 16'hFFFE;
    return m;
  endfunction

  function automatic logic is_gated(input logic [IDX_W-1:0] idx);
    return (idx == IX_DCR) || (idx == IX_DCR2);
  endfunction

  function automatic logic is_tally(input logic [IDX_W-1:0] idx);
    return (idx >= IX_TAL_LO) && (idx <= IX_TAL_HI);
  endfunction

  function automatic logic is_readonly(input logic [IDX_W-1:0] idx);
    return ((idx >= IX_CAP_LO) && (idx <= IX_CAP_HI)) ||
           (idx == IX_REV) || (idx == IX_TAL_RO);
  endfunction

  function automatic logic [15:0] reg_write(input logic [IDX_W-1:0] idx,
                                            input logic [15:0] w);
    return is_tally(idx) ? ~w : (w & wmask(idx));
  endfunction

  function automatic logic [15:0] reset_val(input logic [IDX_W-1:0] idx);
    return (idx == IX_EOBC) ? EOBC_INIT : 16'h0000;
  endfunction

  // accepted command write, effects in their fixed order
  function automatic logic [15:0] cmd_apply(input logic [15:0] cr,
                                            input logic [15:0] w);
    logic [15:0] n;
    n = cr | (w & CMD_MASK);
    if (w[CB_RXDIS])  n[CB_RXEN]   = 1'b0;
    if (w[CB_RXEN])   n[CB_RXDIS]  = 1'b0;
    if (w[CB_TSTOP])  n[CB_TSTART] = 1'b0;
    if (w[CB_TSTART]) n[CB_TSTOP]  = 1'b0;
    if (w[CB_SWRST]) begin
      n[CB_CAM]   = 1'b0;
      n[CB_RSRC]  = 1'b0;
      n[CB_TX]    = 1'b0;
      n[CB_HALT]  = 1'b0;
      n[CB_SWRST] = 1'b1;
      n[CB_RXDIS] = 1'b1;
    end
    return n;
  endfunction

  function automatic logic irq_level(input logic [15:0] m, input logic [15:0] s);
    return |(m & s);
  endfunction

endpackage

// File: rtl/nicr_cmd_ctrl.sv
module nicr_cmd_ctrl
  import nicr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  input  logic             rsrc_kick,
  input  logic [2:0]       engine_done,
  output logic [15:0]      cr_q,
  output cmd_vec_t         cmd_pulse
);

  logic        cr_wr;
  logic        exit_only;
  logic        cmd_take;
  logic [15:0] done_mask;
  logic [15:0] cr_base;
  logic [15:0] cr_d;
  cmd_vec_t    issue;

  assign cr_wr     = wr_en && (idx == IX_CR);
  assign exit_only = cr_wr && cr_q[CB_SWRST] && !wdata[CB_SWRST];
  assign cmd_take  = cr_wr && !exit_only;

  always_comb begin
    done_mask          = '0;
    done_mask[CB_TX]   = engine_done[DN_TX];
    done_mask[CB_RSRC] = engine_done[DN_RSRC];
    done_mask[CB_CAM]  = engine_done[DN_CAM];
  end

  assign cr_base = cr_q & ~done_mask;

  always_comb begin
    cr_d  = cr_base;
    issue = '0;
    if (exit_only) begin
      cr_d[CB_SWRST] = 1'b0;
    end else if (cmd_take) begin
      cr_d  = cmd_apply(cr_base, wdata);
      issue = wdata[CMD_W-1:0] & CMD_MASK[CMD_W-1:0];
    end else if (rsrc_kick) begin
      cr_d[CB_RSRC]  = 1'b1;
      issue[CB_RSRC] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q      <= CR_RESET;
      cmd_pulse <= '0;
    end else begin
      cr_q      <= cr_d;
      cmd_pulse <= issue;
    end
  end

  assert_exit_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exit_only |=> (cmd_pulse == '0) && !cr_q[CB_SWRST]);

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_take || rsrc_kick) |=> (cmd_pulse == '0));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_q[CB_TX] && !engine_done[DN_TX] && !cmd_take) |=> cr_q[CB_TX]);

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (engine_done[DN_TX] && !cmd_take) |=> !cr_q[CB_TX]);

  // R6: a software reset leaves the reset and receiver-disable bits set
  assert_swrst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && wdata[CB_SWRST]) |=> (cr_q[CB_SWRST] && cr_q[CB_RXDIS] && !cr_q[CB_TX]));

endmodule

// File: rtl/nicr_irq_ctrl.sv
module nicr_irq_ctrl
  import nicr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  input  logic [15:0]      isr_set,
  output logic [15:0]      imr_q,
  output logic [15:0]      isr_q,
  output logic             rsrc_kick,
  output logic             irq
);

  logic        imr_wr;
  logic        isr_wr;
  logic [15:0] clr_bits;

  assign imr_wr    = wr_en && (idx == IX_IMR);
  assign isr_wr    = wr_en && (idx == IX_ISR);
  assign clr_bits  = isr_wr ? (wdata & isr_q) : 16'h0000;
  assign rsrc_kick = clr_bits[ISR_RBE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q <= '0;
      isr_q <= '0;
    end else begin
      if (imr_wr) imr_q <= wdata & IMR_MASK;
      isr_q <= (isr_q & ~clr_bits) | isr_set;
    end
  end

  assign irq = irq_level(imr_q, isr_q);

  assert_irq_needs_both_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((imr_q != 16'h0) && (isr_q != 16'h0)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_wr && (isr_set == 16'h0)) |=> ((isr_q & $past(wdata)) == 16'h0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set != 16'h0) |=> ((isr_q & $past(isr_set)) == $past(isr_set)));

  assert_imr_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    imr_wr |=> !imr_q[15]);

endmodule

// File: rtl/nicr_reg_file.sv
module nicr_reg_file
  import nicr_pkg::*;
#(
  parameter logic [15:0] REVISION = 16'h0004
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      wdata,
  input  logic             in_reset,
  output logic [15:0]      rd_word
);

  logic [15:0] words [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : gen_word
    localparam logic [IDX_W-1:0] GI = IDX_W'(g);
    if (GI == IX_CR || GI == IX_IMR || GI == IX_ISR) begin : g_ext
      assign words[g] = 16'h0000;
    end else if (is_readonly(GI)) begin : g_ro
      assign words[g] = (GI == IX_REV) ? REVISION : 16'h0000;
    end else begin : g_rw
      logic [15:0] q;
      logic        hit;
      assign hit = wr_en && (idx == GI) && (!is_gated(GI) || in_reset);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= reset_val(GI);
        else if (hit) q <= reg_write(GI, wdata);
      end
      assign words[g] = q;
    end
  end

  assign rd_word = words[idx];

  assert_gated_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IX_DCR) && !in_reset) |=> $stable(words[IX_DCR]));

  assert_tally_invert_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IX_TAL_LO)) |=> (words[IX_TAL_LO] == ~$past(wdata)));

  assert_ring_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IX_RING_LO)) |=> !words[IX_RING_LO][0]);

endmodule

// File: rtl/nicr_regblock.sv
module nicr_regblock
  import nicr_pkg::*;
#(
  parameter int          STRIDE_SHIFT = 2,
  parameter logic [15:0] REVISION     = 16'h0004
)(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr,
  input  logic                          host_rd,
  input  logic [STRIDE_SHIFT+IDX_W-1:0] host_addr,
  input  logic [15:0]                   host_wdata,
  output logic [15:0]                   host_rdata,
  input  logic [15:0]                   isr_set,
  input  logic [2:0]                    engine_done,
  output logic [CMD_W-1:0]              cmd_pulse,
  output logic                          irq
);

  logic             aligned;
  logic             wr_ok;
  logic             rd_ok;
  logic [IDX_W-1:0] idx;
  logic [15:0]      cr_q;
  logic [15:0]      imr_q;
  logic [15:0]      isr_q;
  logic [15:0]      file_word;
  logic             rsrc_kick;
  logic             in_reset;

  if (STRIDE_SHIFT == 0) begin : g_noalign
    assign aligned = 1'b1;
  end else begin : g_align
    assign aligned = (host_addr[STRIDE_SHIFT-1:0] == '0);
  end

  assign idx      = host_addr[STRIDE_SHIFT +: IDX_W];
  assign wr_ok    = host_wr && aligned;
  assign rd_ok    = host_rd && aligned;
  assign in_reset = cr_q[CB_SWRST];

  nicr_cmd_ctrl u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_ok),
    .idx         (idx),
    .wdata       (host_wdata),
    .rsrc_kick   (rsrc_kick),
    .engine_done (engine_done),
    .cr_q        (cr_q),
    .cmd_pulse   (cmd_pulse)
  );

  nicr_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_ok),
    .idx       (idx),
    .wdata     (host_wdata),
    .isr_set   (isr_set),
    .imr_q     (imr_q),
    .isr_q     (isr_q),
    .rsrc_kick (rsrc_kick),
    .irq       (irq)
  );

  nicr_reg_file #(.REVISION(REVISION)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ok),
    .idx      (idx),
    .wdata    (host_wdata),
    .in_reset (in_reset),
    .rd_word  (file_word)
  );

  always_comb begin
    host_rdata = 16'h0000;
    if (rd_ok) begin
      if (idx == IX_CR)       host_rdata = cr_q;
      else if (idx == IX_IMR) host_rdata = imr_q;
      else if (idx == IX_ISR) host_rdata = isr_q;
      else                    host_rdata = file_word;
    end
  end

  assert_misaligned_wr_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !aligned && (isr_set == 16'h0) && (engine_done == 3'b0))
      |=> ($stable(cr_q) && $stable(imr_q) && $stable(isr_q) && (cmd_pulse == '0)));

endmodule

// File: tb/tb_nicr_regblock.sv
`timescale 1ns/1ps
module tb_nicr_regblock;

  localparam int SS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [SS+5:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic [15:0] isr_set = '0;
  logic [2:0]  engine_done = '0;
  logic [9:0]  cmd_pulse;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;
  logic [15:0] model [64];
  bit in_rst;

  always #10 clk = ~clk;

  nicr_regblock #(.STRIDE_SHIFT(SS), .REVISION(16'h0004)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .isr_set(isr_set), .engine_done(engine_done), .cmd_pulse(cmd_pulse), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [SS+5:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr(input logic [5:0] idx, input logic [15:0] d);
    wr_raw({idx, 2'b00}, d);
  endtask

  task automatic rd_raw(input logic [SS+5:0] a, output logic [15:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 v = host_rdata;
    host_rd = 1'b0;
  endtask

  task automatic rd(input logic [5:0] idx, output logic [15:0] v);
    rd_raw({idx, 2'b00}, v);
  endtask

  task automatic done_strobe(input int which);
    @(negedge clk); engine_done[which] = 1'b1;
    @(negedge clk); engine_done = '0;
  endtask

  task automatic set_status(input logic [15:0] bits);
    @(negedge clk); isr_set = bits;
    @(negedge clk); isr_set = '0;
  endtask

  // expected effect of a host write on a non-command, non-status register
  function automatic logic [15:0] model_wr(input logic [5:0] idx, input logic [15:0] old,
                                           input logic [15:0] w, input bit inr);
    case (idx)
      6'h01: return inr ? (w & 16'hBFFF) : old;
      6'h3F: return inr ? (w & 16'hF017) : old;
      6'h02: return w & 16'hFFE0;
      6'h03: return w & 16'hF000;
      6'h04: return w & 16'h7FFF;
      6'h15, 6'h16, 6'h17, 6'h18: return w & 16'hFFFE;
      6'h2C, 6'h2D, 6'h2E: return ~w;
      6'h22, 6'h23, 6'h24, 6'h28, 6'h2F: return old;
      default: return w;
    endcase
  endfunction

  task automatic random_phase(input int n, input string tag);
    logic [15:0] v;
    for (int i = 0; i < n; i++) begin
      logic [5:0] ix;
      logic [15:0] d;
      ix = 6'($urandom_range(1, 63));
      if (ix == 6'h05) ix = 6'h06;
      d = 16'($urandom);
      wr(ix, d);
      model[ix] = model_wr(ix, model[ix], d, in_rst);
      rd(ix, v);
      check(tag, v, model[ix]);
    end
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    model[6'h13] = 16'h02F8;
    model[6'h28] = 16'h0004;
    in_rst = 1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(6'h00, v); check("R2 cmd reset", v, 16'h0094);
    rd(6'h04, v); check("R2 mask reset", v, 16'h0000);
    rd(6'h05, v); check("R2 status reset", v, 16'h0000);
    rd(6'h13, v); check("R2 eobc reset", v, 16'h02F8);
    rd(6'h28, v); check("R2 revision", v, 16'h0004);
    rd(6'h30, v); check("R2 plain reset", v, 16'h0000);
    check("R2 irq reset", {15'b0, irq}, 16'h0000);
    check("R2 pulses reset", {6'b0, cmd_pulse}, 16'h0000);

    // R9 R10 R11 random writes while held in reset
    random_phase(150, "R9/R10/R11 random in reset");

    // R10 gated writes accepted in reset
    wr(6'h01, 16'hFFFF); model[6'h01] = 16'hBFFF;
    rd(6'h01, v); check("R10 dcr in reset", v, 16'hBFFF);
    wr(6'h3F, 16'hFFFF); model[6'h3F] = 16'hF017;
    rd(6'h3F, v); check("R10 dcr2 in reset", v, 16'hF017);

    // R3 reset exit, command bits ignored
    wr(6'h00, 16'h0008);
    check("R3 no pulse on exit", {6'b0, cmd_pulse}, 16'h0000);
    rd(6'h00, v); check("R3 only reset cleared", v, 16'h0014);
    in_rst = 0;

    // R10 gated write dropped
    wr(6'h01, 16'h0000);
    rd(6'h01, v); check("R10 dcr dropped", v, 16'hBFFF);
    wr(6'h3F, 16'h0000);
    rd(6'h3F, v); check("R10 dcr2 dropped", v, 16'hF017);

    // R4 R5 receiver enable
    wr(6'h00, 16'h0008);
    check("R4 rx enable pulse", {6'b0, cmd_pulse}, 16'h0008);
    rd(6'h00, v); check("R5 rxen clears rxdis", v, 16'h0018);
    check("R4 pulse one cycle", {6'b0, cmd_pulse}, 16'h0000);

    // R5 timer start
    wr(6'h00, 16'h0020);
    check("R4 timer start pulse", {6'b0, cmd_pulse}, 16'h0020);
    rd(6'h00, v); check("R5 start clears stop", v, 16'h0028);

    // R7 transmit busy until done
    wr(6'h00, 16'h0002);
    check("R4 transmit pulse", {6'b0, cmd_pulse}, 16'h0002);
    repeat (4) @(negedge clk);
    rd(6'h00, v); check("R7 transmit held", v, 16'h002A);
    done_strobe(0);
    rd(6'h00, v); check("R7 transmit done clears", v, 16'h0028);

    // R1 R8 interrupt
    wr(6'h04, 16'h0080);
    set_status(16'h0080);
    check("R1 irq high", {15'b0, irq}, 16'h0001);
    wr(6'h05, 16'h0000);
    rd(6'h05, v); check("R8 write zero keeps", v, 16'h0080);
    check("R1 irq still high", {15'b0, irq}, 16'h0001);
    wr(6'h05, 16'h0080);
    check("R1 irq low after clear", {15'b0, irq}, 16'h0000);
    rd(6'h05, v); check("R8 w1c cleared", v, 16'h0000);
    set_status(16'h0100);
    check("R1 masked status no irq", {15'b0, irq}, 16'h0000);
    wr(6'h05, 16'h0100);

    // R8 clearing bit 5 kicks read resource
    set_status(16'h0020);
    wr(6'h05, 16'h0020);
    check("R8 rbe kick pulse", {6'b0, cmd_pulse}, 16'h0100);
    rd(6'h00, v); check("R8 rbe sets cmd bit 8", v, 16'h0128);
    done_strobe(1);
    rd(6'h00, v); check("R7 resource done clears", v, 16'h0028);

    // R6 software reset with pending work
    wr(6'h00, 16'h0201);
    check("R4 halt+cam pulse", {6'b0, cmd_pulse}, 16'h0201);
    wr(6'h00, 16'h0080);
    check("R6 reset pulse", {6'b0, cmd_pulse}, 16'h0080);
    rd(6'h00, v); check("R6 reset state", v, 16'h00AC);

    // leave reset, then cancelling pairs
    wr(6'h00, 16'h0000);
    rd(6'h00, v); check("R3 exit after sw reset", v, 16'h002C);
    wr(6'h00, 16'h0030);
    check("R4 stop+start pulse", {6'b0, cmd_pulse}, 16'h0030);
    rd(6'h00, v); check("R5 stop+start cancel", v, 16'h000C);
    wr(6'h00, 16'h000C);
    rd(6'h00, v); check("R5 rxdis+rxen cancel", v, 16'h0000);

    // R12 misaligned access
    rd(6'h30, v);
    wr_raw({6'h30, 2'b01}, 16'hABCD);
    check("R12 misaligned no pulse", {6'b0, cmd_pulse}, 16'h0000);
    rd(6'h30, v); check("R12 misaligned write ignored", v, model[6'h30]);
    rd_raw({6'h28, 2'b10}, v); check("R12 misaligned read zero", v, 16'h0000);
    wr_raw({6'h00, 2'b10}, 16'h0080);
    rd(6'h00, v); check("R12 misaligned cmd ignored", v, 16'h0000);

    // R11 R9 directed
    wr(6'h2C, 16'h00FF); model[6'h2C] = 16'hFF00;
    rd(6'h2C, v); check("R11 tally inverted", v, 16'hFF00);
    wr(6'h28, 16'h1234);
    rd(6'h28, v); check("R11 revision read-only", v, 16'h0004);
    wr(6'h22, 16'hFFFF);
    rd(6'h22, v); check("R11 table port read-only", v, 16'h0000);
    wr(6'h04, 16'hFFFF); model[6'h04] = 16'h7FFF;
    rd(6'h04, v); check("R9 mask top bit", v, 16'h7FFF);
    wr(6'h16, 16'hFFFF); model[6'h16] = 16'hFFFE;
    rd(6'h16, v); check("R9 ring lsb", v, 16'hFFFE);

    // random writes out of reset
    random_phase(150, "R9/R10/R11 random out of reset");
    check("R1 irq low with empty status", {15'b0, irq}, 16'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule